// File: doc/BRIEF.md
# Fractional Sample-Rate Strobe Generator

This block turns one of two master sample ticks (a 44.1 kHz tick or a 48 kHz tick) into a slower sample strobe. The strobe rate is a rational fraction of the chosen master rate. An error accumulator of the Bresenham kind sets the rate. On each tick of the chosen master it gains a programmed increment. Whenever the running sum reaches the modulus, the block emits a one-cycle strobe and takes the modulus off the sum. Over any span of `mod` master ticks, exactly `inc` strobes appear.

Two registers program the block. A one-bit source select chooses the master tick. A 32-bit rate word holds the increment in its low half. Its high half holds the modulus in a folded form: the value `inc - mod - 1`, truncated to 16 bits. The hardware unfolds this as `mod = inc - field - 1` in 16-bit arithmetic. With the usual increment of 4, the modulus is `4 * master / rate`, which covers rates from 8 kHz up to the master rate.

Top module: `rate_strobe_gen`

## Requirements
- R1: After reset the strobe is low, the 48 kHz tick is selected, and the rate word is zero, which gives an increment of zero. While in this state no strobe is produced for any tick.
- R2: With the source select at 1, only `tick_44k_i` advances the accumulator, and pulses on `tick_48k_i` have no effect.
- R3: With the source select at 0, only `tick_48k_i` advances the accumulator, and pulses on `tick_44k_i` have no effect.
- R4: In the rate word, bits 15:0 hold the increment and bits 31:16 hold the folded modulus field. The modulus is recovered as (increment - field - 1) modulo 2^16.
- R5: On each selected tick, the increment is added to the accumulator. If the sum is greater than or equal to the modulus, the modulus is subtracted and `strobe_o` is high for exactly the one cycle after that tick's clock edge. At all other times `strobe_o` is low.
- R6: Starting from a cleared accumulator, exactly `inc` strobes are produced over any `mod` consecutive selected ticks. The strobe rate is therefore inc × master / mod.
- R7: A write to either register clears the accumulator. A tick in the same cycle as a write is discarded and produces no strobe.
- R8: When the modulus is zero, or smaller than the increment, no strobe is produced and the accumulator holds its value.
- R9: With increment 4 and modulus 4 × master / rate, the rates 48000, 24000, 16000, 12000 and 8000 (from the 48 kHz tick) and 44100, 22050 and 11025 (from the 44.1 kHz tick) each produce one strobe per mod/4 ticks.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_44k_i | input | 1 | One-cycle pulse at the 44.1 kHz master rate |
| tick_48k_i | input | 1 | One-cycle pulse at the 48 kHz master rate |
| src_wr_i | input | 1 | Write strobe for the source-select register |
| src_data_i | input | 1 | Source select value: 1 selects 44.1 kHz, 0 selects 48 kHz |
| rate_wr_i | input | 1 | Write strobe for the rate word |
| rate_data_i | input | 32 | Rate word: folded modulus in bits 31:16, increment in bits 15:0 |
| strobe_o | output | 1 | One-cycle sample strobe |

## Verification
The bench builds the block with its default 16-bit field width. At this width the folded modulus wraps through two's complement for every practical setting. A small modulus written as a large field value therefore tests the unfolding arithmetic directly. Random rate words with small increments and moduli exercise the disabled cases (modulus zero, modulus below increment) and the case where a strobe falls on every tick. They also exercise writes that land on the same cycle as a tick. The standard audio rates are then checked by counting strobes over whole modulus periods of each master.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int FIELD_W = 16;

  typedef enum logic {
    SRC_48K = 1'b0,
    SRC_44K = 1'b1
  } src_e;

  typedef struct packed {
    logic [FIELD_W-1:0] folded_mod;
    logic [FIELD_W-1:0] inc;
  } rate_word_t;
endpackage

// File: rtl/rsg_cfg.sv
module rsg_cfg
  import rsg_pkg::*;
#(
  parameter int W = FIELD_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           src_wr_i,
  input  logic           src_data_i,
  input  logic           rate_wr_i,
  input  logic [2*W-1:0] rate_data_i,
  output src_e           src_o,
  output logic [W-1:0]   inc_o,
  output logic [W-1:0]   mod_o,
  output logic           en_o,
  output logic           clr_o
);
  src_e         src_q;
  logic [W-1:0] inc_q;
  logic [W-1:0] fold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      src_q  <= SRC_48K;
      inc_q  <= '0;
      fold_q <= '0;
    end else begin
      if (src_wr_i) src_q <= src_e'(src_data_i);
      if (rate_wr_i) begin
        inc_q  <= rate_data_i[W-1:0];
        fold_q <= rate_data_i[2*W-1:W];
      end
    end
  end

  // unfold modulus: inc - field - 1, wrapping at W bits
  always_comb begin
    mod_o = inc_q - fold_q - W'(1);
    inc_o = inc_q;
    src_o = src_q;
    en_o  = (mod_o != '0) && (mod_o >= inc_q);
    clr_o = src_wr_i | rate_wr_i;
  end
endmodule

// File: rtl/rsg_tick_sel.sv
module rsg_tick_sel
  import rsg_pkg::*;
(
  input  src_e src_i,
  input  logic tick_44k_i,
  input  logic tick_48k_i,
  output logic tick_o
);
  always_comb begin
    unique case (src_i)
      SRC_44K: tick_o = tick_44k_i;
      default: tick_o = tick_48k_i;
    endcase
  end
endmodule

// File: rtl/rsg_accum.sv
module rsg_accum #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] inc_i,
  input  logic [W-1:0] mod_i,
  output logic         strobe_o
);
  localparam int SUM_W = W + 1;

  logic [W-1:0]     acc_q;
  logic             strobe_q;
  logic [SUM_W-1:0] sum;
  logic             hit;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, inc_i};
    hit = sum >= {1'b0, mod_i};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else if (clr_i) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else if (tick_i && en_i) begin
      if (hit) begin
        acc_q    <= W'(sum - {1'b0, mod_i});
        strobe_q <= 1'b1;
      end else begin
        acc_q    <= W'(sum);
        strobe_q <= 1'b0;
      end
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;

  // R5: a strobe only follows an accepted tick
  a_r5_strobe_after_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_q |-> $past(tick_i && !clr_i));

  // R8: no strobe when the previous cycle's setting was disabled
  a_r8_disabled_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_q |-> $past(en_i));

  // R5: residue stays below the modulus while enabled
  a_r5_residue_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
    en_i |-> (acc_q < mod_i));

  // R7: a register write leaves the accumulator cleared
  a_r7_write_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(clr_i) |-> (acc_q == '0 && !strobe_q));
endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
  import rsg_pkg::*;
#(
  parameter int W = FIELD_W
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           tick_44k_i,
  input  logic           tick_48k_i,
  input  logic           src_wr_i,
  input  logic           src_data_i,
  input  logic           rate_wr_i,
  input  logic [2*W-1:0] rate_data_i,
  output logic           strobe_o
);
  src_e         src;
  logic [W-1:0] inc;
  logic [W-1:0] modv;
  logic         en;
  logic         clr;
  logic         tick;

  rsg_cfg #(.W(W)) u_cfg (
    .clk_i, .rst_i, .src_wr_i, .src_data_i, .rate_wr_i, .rate_data_i,
    .src_o(src), .inc_o(inc), .mod_o(modv), .en_o(en), .clr_o(clr)
  );

  rsg_tick_sel u_sel (
    .src_i(src), .tick_44k_i, .tick_48k_i, .tick_o(tick)
  );

  rsg_accum #(.W(W)) u_acc (
    .clk_i, .rst_i, .tick_i(tick), .clr_i(clr), .en_i(en),
    .inc_i(inc), .mod_i(modv), .strobe_o
  );

  // R1: strobe low in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $past(rst_i) |-> !strobe_o);
endmodule

// File: tb/test_rate_strobe_gen.sv
`timescale 1ns/1ps
module test_rate_strobe_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        t44 = 1'b0, t48 = 1'b0, swr = 1'b0, sdat = 1'b0, rwr = 1'b0;
  logic [31:0] rdat = '0;
  logic        strobe;

  int checks = 0, fails = 0, strobes_seen = 0;
  bit done = 0;

  // model state
  bit          m_sel = 0;
  logic [15:0] m_inc = 0, m_mod = 16'hFFFF;
  int          m_acc = 0;

  always #2.5 clk = ~clk;

  rate_strobe_gen i_rate_strobe_gen (
    .clk_i(clk), .rst_i(rst), .tick_44k_i(t44), .tick_48k_i(t48),
    .src_wr_i(swr), .src_data_i(sdat), .rate_wr_i(rwr),
    .rate_data_i(rdat), .strobe_o(strobe)
  );

  function automatic logic [31:0] pack_rate(int inc, int modv);
    logic [15:0] f;
    f = 16'(inc - modv - 1);
    return {f, 16'(inc)};
  endfunction

  function automatic bit model_step(bit a44, bit a48, bit sw, bit sd,
                                    bit rw, logic [31:0] rd);
    bit tk, en;
    int s;
    if (sw || rw) begin
      if (sw) m_sel = sd;
      if (rw) begin
        m_inc = rd[15:0];
        m_mod = 16'(rd[15:0] - rd[31:16] - 16'd1);
      end
      m_acc = 0;
      return 0;
    end
    tk = m_sel ? a44 : a48;
    en = (m_mod != 0) && (m_mod >= m_inc);
    if (!(tk && en)) return 0;
    s = m_acc + int'(m_inc);
    if (s >= int'(m_mod)) begin
      m_acc = s - int'(m_mod);
      return 1;
    end
    m_acc = s;
    return 0;
  endfunction

  // drive at negedge, check at next negedge
  task automatic step(bit a44, bit a48, bit sw, bit sd, bit rw,
                      logic [31:0] rd, string tag);
    bit exp;
    t44 = a44; t48 = a48; swr = sw; sdat = sd; rwr = rw; rdat = rd;
    exp = model_step(a44, a48, sw, sd, rw, rd);
    @(negedge clk);
    checks++;
    if (strobe) strobes_seen++;
    if (strobe !== exp) begin
      fails++;
      $display("FAIL %s: strobe actual %b expected %b", tag, strobe, exp);
    end
    t44 = 0; t48 = 0; swr = 0; rwr = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic check_count(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: strobe count actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // run n ticks on the chosen master (or the other one), return strobes
  task automatic run_ticks(bit on44, int n, string tag, output int cnt);
    int start;
    start = strobes_seen;
    for (int i = 0; i < n; i++) begin
      step(on44, !on44, 0, 0, 0, 0, tag);
      step(0, 0, 0, 0, 0, 0, tag);
    end
    cnt = strobes_seen - start;
  endtask

  task automatic rate_case(bit on44, int rate, string tag);
    int master, modv, cnt;
    master = on44 ? 44100 : 48000;
    modv = 4 * master / rate;
    step(0, 0, 1, on44, 1, pack_rate(4, modv), tag);
    run_ticks(on44, modv * 3, tag, cnt);
    check_count(cnt, 12, tag);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    checks++;
    if (strobe !== 1'b0) begin
      fails++; $display("FAIL R1: strobe actual %b expected 0", strobe);
    end
    run_ticks(0, 20, "R1", cnt);
    run_ticks(1, 20, "R1", cnt);

    // R4/R5: inc 3, mod 7 -> strobes per model
    step(0, 0, 0, 0, 1, pack_rate(3, 7), "R4");
    run_ticks(0, 7, "R5", cnt);
    check_count(cnt, 3, "R6");

    // R3: 44k ticks ignored while 48k selected
    step(0, 0, 0, 0, 1, pack_rate(4, 4), "R3");
    run_ticks(1, 10, "R3", cnt);
    check_count(cnt, 0, "R3");
    // R2: select 44k, 48k ticks ignored
    step(0, 0, 1, 1, 0, 0, "R2");
    run_ticks(0, 10, "R2", cnt);
    check_count(cnt, 0, "R2");
    run_ticks(1, 5, "R2", cnt);
    check_count(cnt, 5, "R2");

    // R7: partial accumulation then rewrite clears
    step(0, 0, 1, 0, 1, pack_rate(1, 5), "R7");
    run_ticks(0, 4, "R7", cnt);
    step(0, 0, 0, 0, 1, pack_rate(1, 5), "R7");
    run_ticks(0, 4, "R7", cnt);
    check_count(cnt, 0, "R7");
    // write together with tick: tick discarded
    step(0, 1, 0, 0, 1, pack_rate(1, 1), "R7");
    run_ticks(0, 1, "R7", cnt);
    check_count(cnt, 1, "R7");

    // R8: mod zero, mod below inc
    step(0, 0, 0, 0, 1, pack_rate(4, 0), "R8");
    run_ticks(0, 12, "R8", cnt);
    check_count(cnt, 0, "R8");
    step(0, 0, 0, 0, 1, pack_rate(5, 3), "R8");
    run_ticks(0, 12, "R8", cnt);
    check_count(cnt, 0, "R8");

    // R9: standard audio rates
    rate_case(0, 48000, "R9");
    rate_case(0, 24000, "R9");
    rate_case(0, 16000, "R9");
    rate_case(0, 12000, "R9");
    rate_case(0, 8000,  "R9");
    rate_case(1, 44100, "R9");
    rate_case(1, 22050, "R9");
    rate_case(1, 11025, "R9");

    // random mix checked cycle by cycle against the model (R5)
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3)
        step($urandom_range(0,1), $urandom_range(0,1), 0, 0, 1,
             pack_rate($urandom_range(0, 8), $urandom_range(0, 20)), "R5");
      else if (r < 5)
        step($urandom_range(0,1), $urandom_range(0,1), 1,
             $urandom_range(0,1), 0, 0, "R5");
      else
        step($urandom_range(0,1), $urandom_range(0,1), 0, 0, 0, 0, "R5");
    end

    idle(2, "R5");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule